// File: doc/BRIEF.md
# Cross-Coupled Host/Processor Mailbox Registers

This block gives a host driver and an embedded processor separate byte-wide register windows. The host window has 8 addresses and the processor window has 16. Neither side can reach the other's window. A write in one window shows up as status in the other window and raises a pending flag for the receiver. Each receiver clears its own flag with a write-one-to-clear and gates it into an interrupt with its own enable bit. The host controls the processor through three command bits: hold in reset, halt and power-down. A small state machine turns those bits into processor control outputs. The processor sees the command bits, and the state they produced, as read-only status.

The control state machine has four states:
- ST_IN_RESET: the reset state, code 2.
- ST_RUN: code 0.
- ST_HALTED: code 1.
- ST_ASLEEP: code 3.

The transitions are:
- RESET_ASSERT: any state moves to ST_IN_RESET while the reset command is set.
- RESET_RELEASE: ST_IN_RESET moves to ST_HALTED if the halt command is set, otherwise to ST_ASLEEP if power-down is set, otherwise to ST_RUN.
- RUN_HALT and RUN_SLEEP: from ST_RUN, halt is tested first, then power-down.
- HALT_EXIT: ST_HALTED leaves when halt clears, to ST_ASLEEP if power-down is set, otherwise to ST_RUN.
- SLEEP_EXIT: ST_ASLEEP leaves only when power-down clears, to ST_HALTED if halt is set, otherwise to ST_RUN.

Top module: `mbx_xcouple`

## Requirements
- R1: While reset is held and just after it, both read windows report the following: host control (host address 0) reads 0x01, state is ST_IN_RESET, cpu_rst=1, cpu_halt=0, cpu_sleep=0, both pending flags are 0 and both interrupts are 0.
- R2: A host write to address 0 stores wdata AND 0x87: bit0 reset command, bit1 halt command, bit2 power-down command, bit7 host interrupt enable. Host address 0 reads back the stored value. Processor address 0 reads the three command bits in bits [2:0].
- R3: The state register changes on the clock edge after the edge that stored the control byte. Outputs follow the state: cpu_rst in ST_IN_RESET, cpu_halt in ST_HALTED, cpu_sleep in ST_ASLEEP. At most one of the three is high.
- R4: The state machine takes the transitions listed above, and the reset command has priority in every state.
- R5: In ST_ASLEEP a halt command waits until power-down clears. In ST_HALTED a power-down command waits until halt clears.
- R6: The state code is readable in bits [5:4] of host address 1 and of processor address 0.
- R7: Two host writes set the processor pending flag: a write to host address 2 with bit0=1, and any write to host address 3. A write to host address 3 also stores the message byte, which the processor reads at its address 3. The processor flag reads in bit0 of processor address 1 and bit1 of host address 1. p_irq equals the flag AND the enable stored in bit0 of processor address 5.
- R8: Two processor writes set the host pending flag: a write to processor address 2 with bit0=1, and any write to processor address 4. A write to processor address 4 also stores the message byte, which the host reads at its address 4. The host flag reads in bit0 of host address 1 and bit1 of processor address 1. h_irq equals the flag AND host control bit7.
- R9: A write with bit0=1 to the receiver's own address 1 clears its pending flag. A write with bit0=0 there leaves the flag unchanged.
- R10: If a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R11: A host write and a processor write in the same cycle both take effect.
- R12: The following reads return 0 and the following writes change nothing: host addresses 2 and 5–7, and processor addresses 2 and 6–15. Processor writes to its addresses 0, 1 (bit0=0) and 3 also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 3 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from h_addr |
| h_irq | output | 1 | Interrupt to host |
| p_wr | input | 1 | Processor write strobe |
| p_addr | input | 4 | Processor register address |
| p_wdata | input | 8 | Processor write data |
| p_rdata | output | 8 | Processor read data, combinational from p_addr |
| p_irq | output | 1 | Interrupt to processor |
| cpu_rst | output | 1 | Hold processor in reset |
| cpu_halt | output | 1 | Halt processor |
| cpu_sleep | output | 1 | Power down processor |

## Verification
The hardest case to create is a set and a clear hitting the same pending flag on the same edge. It needs writes on both windows aligned to one cycle. The bench drives both windows through a single task per cycle, so it can place a ring from one side and a clear from the other side on the same edge, both on purpose and inside a long random run. The deferred halt and power-down paths take a chosen sequence of control bytes: enter sleep, then add halt, then drop power-down. Each step is checked against a behavioural state model one edge later.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HALTED   = 2'd1,
        ST_IN_RESET = 2'd2,
        ST_ASLEEP   = 2'd3
    } cpu_state_e;

    // host window addresses
    localparam int HA_CTRL  = 0;
    localparam int HA_STAT  = 1;
    localparam int HA_RING  = 2;
    localparam int HA_MSGTX = 3;
    localparam int HA_MSGRX = 4;

    // processor window addresses
    localparam int PA_CMD   = 0;
    localparam int PA_STAT  = 1;
    localparam int PA_RING  = 2;
    localparam int PA_MSGRX = 3;
    localparam int PA_MSGTX = 4;
    localparam int PA_IEN   = 5;

    // host control bit positions
    localparam int CB_RST  = 0;
    localparam int CB_HALT = 1;
    localparam int CB_PD   = 2;
    localparam int CB_IEN  = 7;

    localparam logic [7:0] CTRL_MASK  = 8'h87;
    localparam logic [7:0] CTRL_RESET = 8'h01;
endpackage

// File: rtl/mbx_pend_flag.sv
module mbx_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/mbx_cpu_ctl.sv
module mbx_cpu_ctl
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       halt_req,
    input  logic       pd_req,
    output cpu_state_e state_o,
    output logic       cpu_rst,
    output logic       cpu_halt,
    output logic       cpu_sleep
);
    cpu_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (rst_req)       state_d = ST_IN_RESET;
                else if (halt_req) state_d = ST_HALTED;
                else if (pd_req)   state_d = ST_ASLEEP;
            end
            ST_IN_RESET: begin
                if (!rst_req) begin
                    if (halt_req)    state_d = ST_HALTED;
                    else if (pd_req) state_d = ST_ASLEEP;
                    else             state_d = ST_RUN;
                end
            end
            ST_HALTED: begin
                if (rst_req)        state_d = ST_IN_RESET;
                else if (!halt_req) state_d = pd_req ? ST_ASLEEP : ST_RUN;
            end
            ST_ASLEEP: begin
                if (rst_req)      state_d = ST_IN_RESET;
                else if (!pd_req) state_d = halt_req ? ST_HALTED : ST_RUN;
            end
            default: state_d = ST_IN_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IN_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        cpu_rst   = 1'b0;
        cpu_halt  = 1'b0;
        cpu_sleep = 1'b0;
        unique case (state_q)
            ST_IN_RESET: cpu_rst   = 1'b1;
            ST_HALTED:   cpu_halt  = 1'b1;
            ST_ASLEEP:   cpu_sleep = 1'b1;
            default:     ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/mbx_host_win.sv
module mbx_host_win
    import mbx_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  cpu_state_e    state,
    input  logic          own_pend,
    input  logic          far_pend,
    input  logic [DW-1:0] msg_in,
    output logic [DW-1:0] msg_out,
    output logic [DW-1:0] ctrl,
    output logic          ring_far,
    output logic          clr_own
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= DW'(CTRL_RESET);
            msg_out <= '0;
        end else if (wr) begin
            if (int'(addr) == HA_CTRL)  ctrl    <= wdata & DW'(CTRL_MASK);
            if (int'(addr) == HA_MSGTX) msg_out <= wdata;
        end
    end

    assign ring_far = wr && ((int'(addr) == HA_RING && wdata[0]) || int'(addr) == HA_MSGTX);
    assign clr_own  = wr && int'(addr) == HA_STAT && wdata[0];

    always_comb begin
        rdata = '0;
        case (int'(addr))
            HA_CTRL:  rdata = ctrl;
            HA_STAT: begin
                rdata[0]   = own_pend;
                rdata[1]   = far_pend;
                rdata[5:4] = state;
            end
            HA_MSGTX: rdata = msg_out;
            HA_MSGRX: rdata = msg_in;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_proc_win.sv
module mbx_proc_win
    import mbx_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  cpu_state_e    state,
    input  logic [2:0]    cmd_bits,
    input  logic          own_pend,
    input  logic          far_pend,
    input  logic [DW-1:0] msg_in,
    output logic [DW-1:0] msg_out,
    output logic          irq_en,
    output logic          ring_far,
    output logic          clr_own
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_out <= '0;
            irq_en  <= 1'b0;
        end else if (wr) begin
            if (int'(addr) == PA_MSGTX) msg_out <= wdata;
            if (int'(addr) == PA_IEN)   irq_en  <= wdata[0];
        end
    end

    assign ring_far = wr && ((int'(addr) == PA_RING && wdata[0]) || int'(addr) == PA_MSGTX);
    assign clr_own  = wr && int'(addr) == PA_STAT && wdata[0];

    always_comb begin
        rdata = '0;
        case (int'(addr))
            PA_CMD: begin
                rdata[2:0] = cmd_bits;
                rdata[5:4] = state;
            end
            PA_STAT: begin
                rdata[0] = own_pend;
                rdata[1] = far_pend;
            end
            PA_MSGRX: rdata = msg_in;
            PA_MSGTX: rdata = msg_out;
            PA_IEN:   rdata[0] = irq_en;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_xcouple.sv
module mbx_xcouple
    import mbx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int H_AW = 3,
    parameter int P_AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            h_wr,
    input  logic [H_AW-1:0] h_addr,
    input  logic [DW-1:0]   h_wdata,
    output logic [DW-1:0]   h_rdata,
    output logic            h_irq,
    input  logic            p_wr,
    input  logic [P_AW-1:0] p_addr,
    input  logic [DW-1:0]   p_wdata,
    output logic [DW-1:0]   p_rdata,
    output logic            p_irq,
    output logic            cpu_rst,
    output logic            cpu_halt,
    output logic            cpu_sleep
);
    localparam int N_DIR = 2;   // index 0: toward host, 1: toward processor

    logic [N_DIR-1:0] pend_set, pend_clr, pend_q;
    logic [DW-1:0]    ctrl, msg_h2p, msg_p2h;
    logic             p_ien;
    cpu_state_e       state;
    logic             host_pend, proc_pend;

    assign host_pend = pend_q[0];
    assign proc_pend = pend_q[1];

    mbx_host_win #(.DW(DW), .AW(H_AW)) u_host (
        .clk(clk), .rst_n(rst_n), .wr(h_wr), .addr(h_addr), .wdata(h_wdata),
        .rdata(h_rdata), .state(state), .own_pend(host_pend), .far_pend(proc_pend),
        .msg_in(msg_p2h), .msg_out(msg_h2p), .ctrl(ctrl),
        .ring_far(pend_set[1]), .clr_own(pend_clr[0])
    );

    mbx_proc_win #(.DW(DW), .AW(P_AW)) u_proc (
        .clk(clk), .rst_n(rst_n), .wr(p_wr), .addr(p_addr), .wdata(p_wdata),
        .rdata(p_rdata), .state(state),
        .cmd_bits({ctrl[CB_PD], ctrl[CB_HALT], ctrl[CB_RST]}),
        .own_pend(proc_pend), .far_pend(host_pend),
        .msg_in(msg_h2p), .msg_out(msg_p2h), .irq_en(p_ien),
        .ring_far(pend_set[0]), .clr_own(pend_clr[1])
    );

    for (genvar g = 0; g < N_DIR; g++) begin : g_pend
        mbx_pend_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(pend_set[g]), .clr_i(pend_clr[g]), .q_o(pend_q[g])
        );
    end

    mbx_cpu_ctl u_ctl (
        .clk(clk), .rst_n(rst_n),
        .rst_req(ctrl[CB_RST]), .halt_req(ctrl[CB_HALT]), .pd_req(ctrl[CB_PD]),
        .state_o(state), .cpu_rst(cpu_rst), .cpu_halt(cpu_halt), .cpu_sleep(cpu_sleep)
    );

    assign h_irq = host_pend & ctrl[CB_IEN];
    assign p_irq = proc_pend & p_ien;
endmodule

// File: rtl/mbx_xcouple_chk.sv
module mbx_xcouple_chk #(
    parameter int DW   = 8,
    parameter int H_AW = 3,
    parameter int P_AW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            h_wr,
    input logic [H_AW-1:0] h_addr,
    input logic [DW-1:0]   h_wdata,
    input logic            p_wr,
    input logic [P_AW-1:0] p_addr,
    input logic [DW-1:0]   p_wdata,
    input logic            h_irq,
    input logic            p_irq,
    input logic            cpu_rst,
    input logic            cpu_halt,
    input logic            cpu_sleep,
    input logic            host_pend,
    input logic            proc_pend
);
    p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_rst, cpu_halt, cpu_sleep}));

    p_host_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && int'(h_addr) == 2 && h_wdata[0]) |=> proc_pend);

    p_proc_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (p_wr && int'(p_addr) == 2 && p_wdata[0]) |=> host_pend);

    p_pirq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        p_irq |-> proc_pend);

    p_hirq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        h_irq |-> host_pend);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (p_wr && int'(p_addr) == 1 && p_wdata[0] && h_wr && int'(h_addr) == 2 && h_wdata[0])
        |=> proc_pend);

    p_proc_pend_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_pend) |-> $past(h_wr));

    p_host_pend_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_pend) |-> $past(p_wr));
endmodule

bind mbx_xcouple mbx_xcouple_chk #(.DW(DW), .H_AW(H_AW), .P_AW(P_AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata),
    .h_irq(h_irq), .p_irq(p_irq),
    .cpu_rst(cpu_rst), .cpu_halt(cpu_halt), .cpu_sleep(cpu_sleep),
    .host_pend(host_pend), .proc_pend(proc_pend)
);

// File: tb/test_mbx_xcouple.sv
module test_mbx_xcouple;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_wr = 1'b0;
    logic [2:0] h_addr = '0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic       h_irq;
    logic       p_wr = 1'b0;
    logic [3:0] p_addr = '0;
    logic [7:0] p_wdata = '0;
    logic [7:0] p_rdata;
    logic       p_irq;
    logic       cpu_rst, cpu_halt, cpu_sleep;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural reference state
    int m_ctrl, m_h2p, m_p2h, m_pien, m_hp, m_pp, m_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_xcouple i_mbx_xcouple (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
        .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata), .p_irq(p_irq),
        .cpu_rst(cpu_rst), .cpu_halt(cpu_halt), .cpu_sleep(cpu_sleep)
    );

    // state codes: 0 run, 1 halted, 2 in reset, 3 asleep
    function automatic int next_st(int st, int c);
        int r = c & 1, h = (c >> 1) & 1, d = (c >> 2) & 1;
        if (r != 0) return 2;
        if (st == 3) return (d != 0) ? 3 : ((h != 0) ? 1 : 0);
        if (st == 1 && h != 0) return 1;
        if (h != 0) return 1;
        if (d != 0) return 3;
        return 0;
    endfunction

    function automatic int exp_h(int a);
        case (a)
            0: return m_ctrl;
            1: return (m_st << 4) | (m_pp << 1) | m_hp;
            3: return m_h2p;
            4: return m_p2h;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_p(int a);
        case (a)
            0: return (m_st << 4) | (m_ctrl & 7);
            1: return (m_hp << 1) | m_pp;
            3: return m_h2p;
            4: return m_p2h;
            5: return m_pien;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_ctrl = 1; m_h2p = 0; m_p2h = 0; m_pien = 0; m_hp = 0; m_pp = 0; m_st = 2;
    endtask

    task automatic model_edge();
        int ha = int'(h_addr), pa = int'(p_addr);
        int hd = int'(h_wdata), pd = int'(p_wdata);
        bit pp_set, pp_clr, hp_set, hp_clr;
        if (!rst_n) begin
            model_reset();
            return;
        end
        m_st   = next_st(m_st, m_ctrl);
        pp_set = h_wr && ((ha == 2 && hd[0]) || ha == 3);
        hp_clr = h_wr && ha == 1 && hd[0];
        hp_set = p_wr && ((pa == 2 && pd[0]) || pa == 4);
        pp_clr = p_wr && pa == 1 && pd[0];
        if (pp_set) m_pp = 1; else if (pp_clr) m_pp = 0;
        if (hp_set) m_hp = 1; else if (hp_clr) m_hp = 0;
        if (h_wr && ha == 0) m_ctrl = hd & 8'h87;
        if (h_wr && ha == 3) m_h2p = hd;
        if (p_wr && pa == 4) m_p2h = pd;
        if (p_wr && pa == 5) m_pien = pd & 1;
    endtask

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("h_rdata", int'(h_rdata), exp_h(int'(h_addr)));
        chk("p_rdata", int'(p_rdata), exp_p(int'(p_addr)));
        chk("h_irq", int'(h_irq), m_hp & ((m_ctrl >> 7) & 1));
        chk("p_irq", int'(p_irq), m_pp & m_pien);
        chk("cpu_rst", int'(cpu_rst), int'(m_st == 2));
        chk("cpu_halt", int'(cpu_halt), int'(m_st == 1));
        chk("cpu_sleep", int'(cpu_sleep), int'(m_st == 3));
    endtask

    // one clock: drive, let the edge pass, update model, compare away from the edge
    task automatic cyc(bit hw, int ha, int hd, bit pw, int pa, int pd);
        h_wr = hw; h_addr = 3'(ha); h_wdata = 8'(hd);
        p_wr = pw; p_addr = 4'(pa); p_wdata = 8'(pd);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic hwr(int a, int d); cyc(1, a, d, 0, 0, 0); endtask
    task automatic pwr(int a, int d); cyc(0, 0, 0, 1, a, d); endtask
    task automatic rd(int ha, int pa); cyc(0, ha, 0, 0, pa, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        tag = "R1";
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 1, 0);
        rst_n = 1'b1;
        rd(0, 0); rd(1, 1);

        tag = "R2";
        hwr(0, 8'hFF); rd(0, 0);
        tag = "R4";                     // leave reset into run
        hwr(0, 8'h00); rd(1, 0);
        tag = "R3";                     // one edge of latency
        hwr(0, 8'h02); rd(1, 0);
        tag = "R5";                     // halted ignores power-down until halt drops
        hwr(0, 8'h06); rd(1, 0);
        hwr(0, 8'h04); rd(1, 0);
        tag = "R5";                     // asleep ignores halt until power-down drops
        hwr(0, 8'h06); rd(1, 0);
        hwr(0, 8'h02); rd(1, 0);
        tag = "R4";                     // reset wins from halted, then release to run
        hwr(0, 8'h03); rd(0, 0);
        hwr(0, 8'h04); rd(1, 0);
        hwr(0, 8'h05); rd(1, 0);
        hwr(0, 8'h00); rd(1, 0);
        tag = "R6";
        rd(1, 0);

        tag = "R7";
        hwr(2, 1); rd(1, 1);
        pwr(5, 1); rd(1, 5);
        tag = "R9";
        pwr(1, 0); rd(1, 1);
        pwr(1, 1); rd(1, 1);
        tag = "R7";
        hwr(3, 8'hA5); rd(3, 3);

        tag = "R8";
        pwr(4, 8'h3C); rd(4, 1);
        hwr(0, 8'h80); rd(1, 1);
        tag = "R9";
        hwr(1, 0); rd(1, 1);
        hwr(1, 1); rd(1, 1);

        tag = "R10";
        cyc(1, 2, 1, 1, 1, 1); rd(1, 1);
        cyc(1, 1, 1, 1, 2, 1); rd(1, 1);
        tag = "R11";
        cyc(1, 0, 8'h82, 1, 4, 8'h5A); rd(0, 4);
        cyc(1, 3, 8'h11, 1, 5, 0); rd(3, 3);

        tag = "R12";
        pwr(0, 8'hFF); rd(0, 0);
        pwr(3, 8'hEE); rd(3, 3);
        hwr(5, 8'hFF); hwr(6, 8'hFF); hwr(7, 8'hFF);
        pwr(9, 8'hFF); pwr(15, 8'hFF);
        for (int a = 0; a < 16; a++) rd(a % 8, a);

        tag = "R11";
        for (int i = 0; i < 600; i++) begin
            int ha = $urandom_range(0, 7);
            int pa = $urandom_range(0, 7);
            int hd = $urandom_range(0, 255);
            if (ha == 0 && $urandom_range(0, 3) != 0) hd = hd & 8'h86;
            cyc(1'($urandom_range(0, 1)), ha, hd,
                1'($urandom_range(0, 1)), pa, $urandom_range(0, 255));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule